// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a two-wire bus slave that gives a host read and write access to a small file of configuration bytes. The host addresses the device with a 7-bit address. The upper five bits of that address are fixed. The two low bits come from one of the block's own registers, so that up to four of these slaves can share one bus. After a write address, the host sends a command byte. It selects either a single-byte or a sequential transfer, together with the starting register offset. Further data bytes are written one by one, and each takes effect as soon as its last bit is sampled. A read is set up with a command byte and then a repeated START with the read address. A sequential read returns as many bytes as a count field in the general configuration byte specifies.

The block also drives a commit request toward a nonvolatile-storage stub and accepts that stub's busy flag. While busy is high, written data bytes are refused, but reads are still served. The busy flag can be read back as a status bit. A mode bit turns the two bus pins into plain control inputs. In that mode the slave ignores any new transaction.

SDA and SCL arrive as separate level inputs. The slave pulls SDA low by raising an output enable, and the pad drives the value on `sda_o`, which is always 0. Both pins are passed through two-flop synchronisers into the system clock.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1101 1 followed by register 1 bits [1:0], with bit 0 of the byte selecting read (1) or write (0). For any other address, SDA output enable stays low for the whole transfer.
- R2: A command byte with bit 7 = 1 selects single-byte mode, and bits [6:0] give the offset. In a single-byte write only the first data byte is stored. A second data byte is not acknowledged and is not stored.
- R3: A command byte with bit 7 = 0 selects block mode. Data bytes are stored at ascending offsets starting at the command offset. Each byte appears on `regs_o` (byte i at bits [8i+7:8i]) before the SCL rise of its acknowledge bit, and a write may stop after any byte.
- R4: A single-byte read returns the byte at the offset, MSB first, and then 0xFF. Register 1 reads as {0, busy, stored bits [5:0]}.
- R5: A block read returns register 2 bits [3:0] bytes from ascending offsets. After that count is used up, the slave releases SDA, so the host reads 0xFF.
- R6: Offsets at or above the register count (8 by default) are acknowledged on write with no effect, and they read as 0x00.
- R7: While `commit_busy_i` is high, data bytes of a write are not acknowledged and no register changes. Reads still return correct data.
- R8: Writing register 1 with bit 7 = 1 produces a `commit_req_o` pulse exactly one clock wide. Bits 7 and 6 of register 1 are never stored.
- R9: With register 2 bit 6 = 1 (pin mode), `ctrl_o` = {synchronised SCL, synchronised SDA} and a new START is ignored. With bit 6 = 0 (the reset value), `ctrl_o` = 0.
- R10: After reset, register 2 holds 0x08, every other register holds 0x00, SDA output enable is low and `commit_req_o` is low.
- R11: A repeated START at any point restarts address decoding, including after a refused address.
- R12: Transfers work at two bus rates that differ by a factor of four, whenever each SCL high and low phase lasts at least 8 system clocks. SDA output enable never changes while SCL is high, except on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_o | output | 1 | SDA drive value, always 0 |
| sda_oe_o | output | 1 | SDA pull-down enable |
| regs_o | output | NREG*8 | Register file contents, byte i at [8i+7:8i] |
| commit_req_o | output | 1 | One-cycle commit request to the storage stub |
| commit_busy_i | input | 1 | Storage commit in progress |
| ctrl_o | output | 2 | Pin-mode levels {SCL, SDA}, zero in serial mode |

## Verification
The hardest state to reach is a busy window that overlaps whole bus transactions. The bench makes the busy stub hold its flag for thousands of clocks after a commit write. Inside that window it issues a write that must be refused and a status read that must show the flag set. The exact moment a write takes effect is also hard to observe. The bench snapshots `regs_o` in the middle of the SCL high phase of each eighth data bit. Random mixes of block and single transfers at both rates run against a bench-side byte model, and that model also tracks the programmable address bits.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK} bus_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} rx_ph_e;
  localparam logic [4:0] ADDR_PFX   = 5'b11011;
  localparam int         CNT_W      = 4;
  localparam int         REG_ID     = 1;
  localparam int         REG_GEN    = 2;
  localparam int         BUSY_BIT   = 6;
  localparam int         COMMIT_BIT = 7;
  localparam int         PIN_BIT    = 6;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= 2'b11;
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_start_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges are only meaningful while SCL is steadily high
  assign start_o = en_start_i & scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [6:0]        waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [6:0]        raddr_i,
  input  logic              busy_i,
  output logic [7:0]        rdata_o,
  output logic [NREG*8-1:0] regs_o,
  output logic [1:0]        dev_lo_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              pin_mode_o,
  output logic              commit_req_o
);
  localparam int CNT_RST = (NREG > 15) ? 15 : NREG;

  logic [7:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] RST_V = (i == REG_GEN) ? 8'(CNT_RST) : 8'h00;
    localparam logic [7:0] MASK  = (i == REG_ID)  ? 8'h3F : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem[i] <= RST_V;
      else if (we_i && waddr_i == 7'(i))   mem[i] <= wdata_i & MASK;
    end
    assign regs_o[8*i +: 8] = mem[i];
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (raddr_i == 7'(i))
        rdata_o = (i == REG_ID) ? {1'b0, busy_i, mem[i][5:0]} : mem[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_req_o <= 1'b0;
    else         commit_req_o <= we_i && waddr_i == 7'(REG_ID) && wdata_i[COMMIT_BIT];
  end

  assign dev_lo_o   = mem[REG_ID][1:0];
  assign byte_cnt_o = mem[REG_GEN][CNT_W-1:0];
  assign pin_mode_o = mem[REG_GEN][PIN_BIT];
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o,
  output logic              commit_req_o,
  input  logic              commit_busy_i,
  output logic [1:0]        ctrl_o
);
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, ev_start, ev_stop;
  logic             pin_mode;
  logic [1:0]       dev_lo;
  logic [CNT_W-1:0] byte_cnt, rd_left;
  logic [7:0]       rd_data, rx_byte, tx_next;
  bus_st_e          st;
  rx_ph_e           ph;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg, tx_sh, ptr, wr_addr;
  logic [7:0]       wr_data;
  logic             wr_en, byte_full, ack_q, rd_q, single_q, wrote_q, nack_q;

  i2c_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_line_events u_ev (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_start_i(~pin_mode),
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(ev_start), .stop_o(ev_stop)
  );

  cfg_regfile #(.NREG(NREG)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(ptr), .busy_i(commit_busy_i), .rdata_o(rd_data),
    .regs_o(regs_o), .dev_lo_o(dev_lo), .byte_cnt_o(byte_cnt),
    .pin_mode_o(pin_mode), .commit_req_o(commit_req_o)
  );

  assign sda_o   = 1'b0;
  assign ctrl_o  = pin_mode ? {scl_s, sda_s} : 2'b00;
  assign rx_byte = {shreg, sda_s};
  // an exhausted read budget leaves SDA released
  assign tx_next = (rd_left != '0) ? rd_data : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; ph <= PH_ADDR; bit_cnt <= '0;
      shreg <= '0; tx_sh <= '0; ptr <= '0; rd_left <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      byte_full <= 1'b0; ack_q <= 1'b0; rd_q <= 1'b0;
      single_q <= 1'b0; wrote_q <= 1'b0; nack_q <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        st <= ST_RX; ph <= PH_ADDR; bit_cnt <= '0;
        byte_full <= 1'b0; sda_oe_o <= 1'b0;
      end else if (ev_stop) begin
        st <= ST_IDLE; sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= rx_byte[6:0];
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                byte_full <= 1'b1;
                unique case (ph)
                  PH_ADDR: begin
                    ack_q   <= (rx_byte[7:1] == {ADDR_PFX, dev_lo});
                    rd_q    <= rx_byte[0];
                    rd_left <= single_q ? CNT_W'(1) : byte_cnt;
                    ph      <= PH_CMD;
                  end
                  PH_CMD: begin
                    single_q <= rx_byte[7];
                    ptr      <= rx_byte[6:0];
                    wrote_q  <= 1'b0;
                    ack_q    <= 1'b1;
                    ph       <= PH_DATA;
                  end
                  default: begin
                    if (commit_busy_i || (single_q && wrote_q)) begin
                      ack_q <= 1'b0;
                    end else begin
                      ack_q   <= 1'b1;
                      wr_en   <= 1'b1;
                      wr_addr <= ptr;
                      wr_data <= rx_byte;
                      ptr     <= ptr + 7'd1;
                      wrote_q <= 1'b1;
                    end
                  end
                endcase
              end
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              sda_oe_o  <= ack_q;
              st        <= ST_RACK;
            end
          end
          ST_RACK, ST_TACK: begin
            if (st == ST_TACK && scl_rise) nack_q <= sda_s;
            if (scl_fall) begin
              if ((st == ST_RACK && !ack_q) || (st == ST_TACK && nack_q)) begin
                st <= ST_IDLE; sda_oe_o <= 1'b0;
              end else if (st == ST_TACK || rd_q) begin
                tx_sh    <= tx_next[6:0];
                sda_oe_o <= ~tx_next[7];
                if (rd_left != '0) begin
                  ptr     <= ptr + 7'd1;
                  rd_left <= rd_left - CNT_W'(1);
                end
                bit_cnt <= '0;
                st      <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0; bit_cnt <= '0; st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_oe_o <= 1'b0; st <= ST_TACK;
              end else begin
                sda_oe_o <= ~tx_sh[6];
                tx_sh    <= {tx_sh[5:0], 1'b0};
                bit_cnt  <= bit_cnt + 3'd1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              sda_oe_o,
  input bus_st_e           st,
  input logic              wr_en,
  input logic              commit_busy_i,
  input logic              commit_req_o,
  input logic              pin_mode,
  input logic [NREG*8-1:0] regs_o
);
  AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IDLE |-> !sda_oe_o); // R1
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o)); // R3
  AST_NO_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !$past(commit_busy_i)); // R7
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_o |=> !commit_req_o); // R8
  AST_PIN_MODE_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mode && st == ST_IDLE |=> st == ST_IDLE); // R9
  AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_s && $past(scl_s) && !$past(ev_start) && !$past(ev_stop) |-> $stable(sda_oe_o)); // R12
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .ev_start(ev_start), .ev_stop(ev_stop),
  .sda_oe_o(sda_oe_o), .st(st), .wr_en(wr_en), .commit_busy_i(commit_busy_i),
  .commit_req_o(commit_req_o), .pin_mode(pin_mode), .regs_o(regs_o)
);

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int BUSY_LEN = 6000;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o, sda_oe, commit_req, busy;
  logic [NREG*8-1:0] regs;
  logic [1:0] ctrl;
  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_slave #(.NREG(NREG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .regs_o(regs),
    .commit_req_o(commit_req), .commit_busy_i(busy), .ctrl_o(ctrl)
  );

  // storage stub
  int bcnt = 0, npulse = 0, req_cycles = 0;
  always @(posedge clk) begin
    if (commit_req) begin bcnt <= BUSY_LEN; npulse <= npulse + 1; req_cycles <= req_cycles + 1; end
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end
  assign busy = (bcnt != 0);

  logic oe_seen = 1'b0;
  always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

  int nerr = 0, nchk = 0, half = 20;
  logic [7:0] expm [NREG];
  logic [1:0] dev = 2'b00;
  logic [NREG*8-1:0] snap;
  logic [7:0] wbuf [16], rbuf [16];
  logic       ackv [16];
  logic [NREG*8-1:0] snapv [16];
  logic       a_ack, c_ack;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  function automatic logic [7:0] exp_rd(input int off);
    if (off >= NREG) return 8'h00;
    if (off == 1) return {1'b0, busy, expm[1][5:0]};
    return expm[off];
  endfunction

  function automatic void apply(input int off, input logic [7:0] v);
    if (off < NREG) expm[off] = (off == 1) ? (v & 8'h3F) : v;
  endfunction

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    hw(half/2); sda_m = b; hw(half/2); scl_m = 1'b1; hw(half/2); snap = regs; hw(half/2); scl_m = 1'b0;
  endtask
  task automatic bit_in(output logic b);
    hw(half/2); sda_m = 1'b1; hw(half/2); scl_m = 1'b1; hw(half/2); b = sda_line; hw(half/2); scl_m = 1'b0;
  endtask
  task automatic i2c_start;
    hw(half/2); sda_m = 1'b1; hw(half/2); scl_m = 1'b1; hw(half/2); sda_m = 1'b0; hw(half/2); scl_m = 1'b0;
  endtask
  task automatic i2c_stop;
    hw(half/2); sda_m = 1'b0; hw(half/2); scl_m = 1'b1; hw(half/2); sda_m = 1'b1; hw(half);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r); ack = !r;
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(!mack);
  endtask

  task automatic wr_txn(input logic single, input int off, input int n);
    i2c_start;
    send_byte({5'b11011, dev, 1'b0}, a_ack);
    send_byte({single, 7'(off)}, c_ack);
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], ackv[k]); snapv[k] = snap; end
    i2c_stop;
  endtask

  task automatic rd_txn(input logic single, input int off, input int n);
    logic x;
    i2c_start;
    send_byte({5'b11011, dev, 1'b0}, a_ack);
    send_byte({single, 7'(off)}, c_ack);
    i2c_start;
    send_byte({5'b11011, dev, 1'b1}, x);
    a_ack = a_ack & x;
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k < n-1);
    i2c_stop;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[8*i +: 8] == expm[i], req, regs[8*i +: 8], expm[i]);
  endtask

  task automatic run_all;
    logic x;
    int off, n, cnt;
    logic [7:0] v, e;
    for (int i = 0; i < NREG; i++) expm[i] = (i == 2) ? 8'h08 : 8'h00;
    hw(5); rst_n = 1'b1; hw(5);
    // R10 reset state
    chk_regs("R10");
    chk(sda_oe == 1'b0 && commit_req == 1'b0, "R10", {sda_oe, commit_req}, 0);
    chk(ctrl == 2'b00, "R9", ctrl, 0);

    // R2 single write
    wbuf[0] = 8'hA5; wr_txn(1'b1, 0, 1); apply(0, 8'hA5);
    chk(a_ack && c_ack && ackv[0], "R2", {a_ack, c_ack, ackv[0]}, 3'b111);
    chk(snapv[0][7:0] == 8'hA5, "R3", snapv[0][7:0], 8'hA5);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wr_txn(1'b1, 3, 2); apply(3, 8'h11);
    chk(ackv[0] && !ackv[1], "R2", {ackv[0], ackv[1]}, 2'b10);
    chk_regs("R2");

    // R3 block write, each byte visible before its ack clock
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h30 + 8'(k);
    wr_txn(1'b0, 3, 4);
    for (int k = 0; k < 4; k++) begin
      apply(3 + k, wbuf[k]);
      chk(ackv[k] && snapv[k][8*(3+k) +: 8] == wbuf[k], "R3", snapv[k][8*(3+k) +: 8], wbuf[k]);
    end
    // R6 block write running past the end
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
    wr_txn(1'b0, 6, 4); apply(6, 8'hC0); apply(7, 8'hC1);
    chk(ackv[2] && ackv[3], "R6", {ackv[2], ackv[3]}, 2'b11);
    chk_regs("R6");

    // R4 single read with trailing byte
    rd_txn(1'b1, 3, 2);
    chk(rbuf[0] == 8'h30 && rbuf[1] == 8'hFF, "R4", {rbuf[0], rbuf[1]}, 16'h30FF);
    // R5 block read with count 3
    wbuf[0] = 8'h03; wr_txn(1'b1, 2, 1); apply(2, 8'h03);
    rd_txn(1'b0, 3, 4);
    chk(rbuf[0] == 8'h30 && rbuf[1] == 8'h31 && rbuf[2] == 8'h32, "R5", {rbuf[0], rbuf[1], rbuf[2]}, 24'h303132);
    chk(rbuf[3] == 8'hFF, "R5", rbuf[3], 8'hFF);
    rd_txn(1'b1, 9, 1);
    chk(rbuf[0] == 8'h00, "R6", rbuf[0], 8'h00);

    // R1 address decode
    oe_seen = 1'b0;
    i2c_start; send_byte({5'b11011, 2'b01, 1'b0}, x); i2c_stop;
    chk(!x && !oe_seen, "R1", {x, oe_seen}, 0);
    wbuf[0] = 8'h02; wr_txn(1'b1, 1, 1); apply(1, 8'h02); dev = 2'b10;
    i2c_start; send_byte({5'b11011, 2'b00, 1'b0}, x); i2c_stop;
    chk(!x, "R1", x, 0);
    rd_txn(1'b1, 1, 1);
    chk(a_ack && rbuf[0] == 8'h02, "R1", {a_ack, rbuf[0]}, {1'b1, 8'h02});

    // R11 repeated START after a refused address
    i2c_start; send_byte({5'b11011, 2'b11, 1'b0}, x);
    i2c_start; send_byte({5'b11011, dev, 1'b0}, a_ack);
    send_byte(8'h80, c_ack); send_byte(8'h5A, ackv[0]); i2c_stop; apply(0, 8'h5A);
    chk(!x && a_ack && ackv[0] && regs[7:0] == 8'h5A, "R11", {x, a_ack, ackv[0], regs[7:0]}, {3'b011, 8'h5A});

    // R12 slow rate
    half = 80;
    wbuf[0] = 8'h9C; wbuf[1] = 8'h6E; wr_txn(1'b0, 4, 2); apply(4, 8'h9C); apply(5, 8'h6E);
    rd_txn(1'b0, 4, 2);
    chk(rbuf[0] == 8'h9C && rbuf[1] == 8'h6E, "R12", {rbuf[0], rbuf[1]}, 16'h9C6E);
    half = 20;

    // random mix
    void'($urandom(32'd1234));
    for (int it = 0; it < 30; it++) begin
      half = ($urandom % 8 == 0) ? 80 : 20;
      off = $urandom_range(0, 9);
      if ($urandom % 2 == 0) begin
        n = $urandom_range(1, 4);
        for (int k = 0; k < n; k++) begin
          v = 8'($urandom);
          if (off + k == 1) v = v & 8'h7F;
          if (off + k == 2) v = 8'($urandom_range(1, 5));
          wbuf[k] = v;
        end
        wr_txn(1'b0, off, n);
        for (int k = 0; k < n; k++) begin
          apply(off + k, wbuf[k]);
          chk(ackv[k], "R3", ackv[k], 1);
        end
        dev = expm[1][1:0];
        chk_regs("R3");
      end else begin
        cnt = int'(expm[2][3:0]);
        rd_txn(1'b0, off, cnt + 1);
        for (int k = 0; k <= cnt; k++) begin
          e = (k < cnt) ? exp_rd(off + k) : 8'hFF;
          chk(rbuf[k] == e, "R5", rbuf[k], e);
        end
      end
    end
    half = 20;

    // R8 commit and R7 busy window
    npulse = 0; req_cycles = 0;
    wbuf[0] = {2'b11, 4'h0, dev}; wr_txn(1'b1, 1, 1); apply(1, wbuf[0]);
    hw(4);
    chk(npulse == 1 && req_cycles == 1, "R8", {npulse[15:0], req_cycles[15:0]}, 32'h00010001);
    chk(regs[15:8] == {6'h0, dev}, "R8", regs[15:8], {6'h0, dev});
    chk(busy, "R7", busy, 1);
    v = expm[0];
    wbuf[0] = ~v; wr_txn(1'b1, 0, 1);
    chk(a_ack && c_ack && !ackv[0], "R7", {a_ack, c_ack, ackv[0]}, 3'b110);
    chk(regs[7:0] == v, "R7", regs[7:0], v);
    rd_txn(1'b1, 1, 1);
    chk(rbuf[0] == {2'b01, 4'h0, dev}, "R4", rbuf[0], {2'b01, 4'h0, dev});
    wait (!busy); hw(4);
    rd_txn(1'b1, 1, 1);
    chk(rbuf[0] == {2'b00, 4'h0, dev}, "R7", rbuf[0], {2'b00, 4'h0, dev});

    // R9 pin mode
    wbuf[0] = 8'h43; wr_txn(1'b1, 2, 1); apply(2, 8'h43);
    chk(ackv[0], "R9", ackv[0], 1);
    hw(10);
    chk(ctrl == 2'b11, "R9", ctrl, 2'b11);
    scl_m = 1'b0; hw(10); sda_m = 1'b0; hw(10);
    chk(ctrl == 2'b00, "R9", ctrl, 2'b00);
    sda_m = 1'b1; hw(10);
    chk(ctrl == 2'b01, "R9", ctrl, 2'b01);
    oe_seen = 1'b0;
    i2c_start; send_byte({5'b11011, dev, 1'b0}, x); i2c_stop;
    chk(!x && !oe_seen, "R9", {x, oe_seen}, 0);
  endtask

  initial begin
    bit wd_hit = 1'b0;
    fork
      run_all();
      begin repeat (WD_CYCLES) @(posedge clk); wd_hit = 1'b1; end
    join_any
    if (wd_hit) begin nchk++; nerr++; $display("FAIL watchdog act=timeout exp=done"); end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule